// File: doc/BRIEF.md
# Multi-cluster CPU reset controller

This block holds the reset lines of up to four processor clusters, each with four cores. Every core has three lines of its own (core logic, vector unit and core debug), and every cluster has two shared lines (its L2 cache and its cluster debug logic). Software changes these lines only through two write-only registers per cluster. Writing ones to the assert register puts the chosen lines into reset. Writing ones to the release register takes them out. Zero bits leave a line as it is.

A change on a line does not take effect at once. It reaches the reset output, and the read-only status register of the cluster, a fixed number of clock cycles after the write (`RELEASE_LAG`). Software therefore polls status until the change shows. Each line keeps its own delay.

The status word also carries three signals from every core: whether it is waiting for an interrupt, whether it is waiting for an event, and its debug acknowledge. These come from input ports through a two-flop synchroniser. The bus is a plain register port: address, write strobe, write data, and read data that follows the address combinationally.

Top module: `mcrst_top`

## Requirements
- R1: For cluster c below NUM_CLUSTERS, the registers sit at these addresses: the assert register at 0x520 + 8c, the release register at 0x524 + 8c, and the status register at 0x1520 + 8c.
- R2: The control and status words share one bit layout for the reset lines: bit n (n = 0..3) is core n logic, bit n+4 is core n vector unit, bit 8 is the cluster L2, bit n+9 is core n debug, and bit 13 is the cluster debug. Write data bits 14 to 31 have no effect.
- R3: A 1 written to a bit of the assert register puts that line into reset. A 1 written to a bit of the release register takes it out of reset. A 0 bit leaves the line unchanged.
- R4: Status bits 13:0 read 1 for a line held in reset and 0 for a released line. They always equal that cluster's slice of `line_rst_o`, which is bits 14c+13 to 14c.
- R5: A write that changes a line reaches `line_rst_o` and status exactly RELEASE_LAG clock edges after the edge that takes the write, and no earlier.
- R6: Each line has its own delay. A new write to a line before its change has shown restarts that line's delay, and the last write decides the final value. Pending changes on other lines keep their own timing.
- R7: After the controller's reset, every line is held in reset, with one exception: cluster 0 comes up with core 0 logic, vector and debug, its L2 and its cluster debug released. This gives status 0x1CEE for cluster 0 and 0x3FFF for every other cluster.
- R8: Status bit 16+n shows core n waiting for an interrupt, bit 20+n shows core n waiting for an event, and bit 24+n shows core n's debug acknowledge. Each is taken from its input port (flat index 4c+n) two clock edges after the input changes.
- R9: These addresses read zero: unmapped addresses and the assert and release registers. Status bits 14, 15 and 28 to 31 also read zero. Writes to unmapped addresses and to status registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| bus_addr_i | input | 16 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, takes bus_wdata_i at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| core_wfi_i | input | 4*NUM_CLUSTERS | Per-core wait-for-interrupt state, index 4c+n |
| core_wfe_i | input | 4*NUM_CLUSTERS | Per-core wait-for-event state, index 4c+n |
| core_dbgack_i | input | 4*NUM_CLUSTERS | Per-core debug acknowledge, index 4c+n |
| line_rst_o | output | 14*NUM_CLUSTERS | Reset lines, 1 = held in reset, cluster c at bits 14c+13:14c |

## Verification
The hardest case to reach is two writes overlapping inside one delay window. In one form, two different lines of a cluster are changed a few cycles apart, and each must appear exactly RELEASE_LAG edges after its own write. In the other, one line is written again before its first change has shown, so its delay must restart. The stimulus gets there by issuing the second write a fixed number of cycles after the first. It then reads status just before and just at each expected edge, and also covers a release that is cancelled by an assert before it can appear.

// File: rtl/mcrst_pkg.sv
package mcrst_pkg;

    // Reset lines per cluster and cores per cluster (fixed by the bit layout)
    localparam int LINE_BITS    = 14;
    localparam int CORE_SLOTS   = 4;
    localparam int IDLE_BITS    = 3 * CORE_SLOTS;
    localparam int MAX_CLUSTERS = 4;

    localparam logic [15:0] ASSERT_BASE  = 16'h0520;
    localparam logic [15:0] RELEASE_BASE = 16'h0524;
    localparam logic [15:0] STATUS_BASE  = 16'h1520;
    localparam int          CLUSTER_STEP = 8;

    // Lines of cluster 0 that leave reset released: core0 logic/vector/debug, L2, cluster debug
    localparam logic [LINE_BITS-1:0] BOOT_RELEASED = 14'h2311;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_ASSERT,
        REG_RELEASE,
        REG_STATUS
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  cluster;
    } reg_sel_t;

    typedef struct packed {
        logic [CORE_SLOTS-1:0] dbgack;
        logic [CORE_SLOTS-1:0] wfe;
        logic [CORE_SLOTS-1:0] wfi;
    } core_idle_t;

    function automatic reg_sel_t decode_addr(input logic [15:0] a, input int n_clusters);
        reg_sel_t s;
        s.kind    = REG_NONE;
        s.cluster = '0;
        for (int c = 0; c < n_clusters; c++) begin
            if (a == ASSERT_BASE + 16'(CLUSTER_STEP * c)) begin
                s.kind    = REG_ASSERT;
                s.cluster = 2'(c);
            end
            if (a == RELEASE_BASE + 16'(CLUSTER_STEP * c)) begin
                s.kind    = REG_RELEASE;
                s.cluster = 2'(c);
            end
            if (a == STATUS_BASE + 16'(CLUSTER_STEP * c)) begin
                s.kind    = REG_STATUS;
                s.cluster = 2'(c);
            end
        end
        return s;
    endfunction

    function automatic logic [31:0] pack_status(input logic [LINE_BITS-1:0] lines,
                                                input core_idle_t idle);
        return {4'b0000, idle.dbgack, idle.wfe, idle.wfi, 2'b00, lines};
    endfunction

    function automatic logic [LINE_BITS-1:0] init_mask(input int cluster);
        return (cluster == 0) ? ~BOOT_RELEASED : {LINE_BITS{1'b1}};
    endfunction

endpackage

// File: rtl/mcrst_line_delay.sv
module mcrst_line_delay #(
    parameter int LAG  = 16,
    parameter bit INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic line_o
);
    localparam int CW = $clog2(LAG + 1);

    logic          pend_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= INIT;
            line_o <= INIT;
            cnt_q  <= '0;
        end else if (set_i || clr_i) begin
            // assert has priority; any write restarts this line's delay
            pend_q <= set_i;
            cnt_q  <= CW'(LAG);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                line_o <= pend_q;
            end
        end
    end
endmodule

// File: rtl/mcrst_idle_sync.sv
module mcrst_idle_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/mcrst_cluster_bank.sv
module mcrst_cluster_bank
    import mcrst_pkg::*;
#(
    parameter int                   LAG       = 16,
    parameter logic [LINE_BITS-1:0] INIT_MASK = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINE_BITS-1:0]  set_mask_i,
    input  logic [LINE_BITS-1:0]  clr_mask_i,
    input  logic [CORE_SLOTS-1:0] wfi_i,
    input  logic [CORE_SLOTS-1:0] wfe_i,
    input  logic [CORE_SLOTS-1:0] dbgack_i,
    output logic [LINE_BITS-1:0]  lines_o,
    output logic [31:0]           status_o
);
    core_idle_t           idle_sync;
    logic [IDLE_BITS-1:0] idle_raw;
    logic [IDLE_BITS-1:0] idle_flat;

    for (genvar i = 0; i < LINE_BITS; i++) begin : g_line
        mcrst_line_delay #(
            .LAG  (LAG),
            .INIT (INIT_MASK[i])
        ) line_i (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_mask_i[i]),
            .clr_i  (clr_mask_i[i]),
            .line_o (lines_o[i])
        );
    end

    assign idle_raw = {dbgack_i, wfe_i, wfi_i};

    mcrst_idle_sync #(
        .WIDTH (IDLE_BITS)
    ) idle_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (idle_raw),
        .sync_o  (idle_flat)
    );

    assign idle_sync = core_idle_t'(idle_flat);
    assign status_o  = pack_status(lines_o, idle_sync);
endmodule

// File: rtl/mcrst_top.sv
module mcrst_top
    import mcrst_pkg::*;
#(
    parameter int NUM_CLUSTERS = 4,
    parameter int RELEASE_LAG  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [15:0]                       bus_addr_i,
    input  logic                              bus_wr_i,
    input  logic [31:0]                       bus_wdata_i,
    output logic [31:0]                       bus_rdata_o,
    input  logic [CORE_SLOTS*NUM_CLUSTERS-1:0] core_wfi_i,
    input  logic [CORE_SLOTS*NUM_CLUSTERS-1:0] core_wfe_i,
    input  logic [CORE_SLOTS*NUM_CLUSTERS-1:0] core_dbgack_i,
    output logic [LINE_BITS*NUM_CLUSTERS-1:0]  line_rst_o
);
    reg_sel_t    sel;
    logic [31:0] status_arr [NUM_CLUSTERS];
    logic        unused_wdata_hi;

    assign sel             = decode_addr(bus_addr_i, NUM_CLUSTERS);
    assign unused_wdata_hi = ^bus_wdata_i[31:LINE_BITS];

    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cluster
        logic [LINE_BITS-1:0] set_mask;
        logic [LINE_BITS-1:0] clr_mask;
        logic                 hit;

        assign hit      = bus_wr_i && (sel.cluster == 2'(c));
        assign set_mask = (hit && sel.kind == REG_ASSERT)  ? bus_wdata_i[LINE_BITS-1:0] : '0;
        assign clr_mask = (hit && sel.kind == REG_RELEASE) ? bus_wdata_i[LINE_BITS-1:0] : '0;

        mcrst_cluster_bank #(
            .LAG       (RELEASE_LAG),
            .INIT_MASK (init_mask(c))
        ) bank_i (
            .clk        (clk),
            .rst        (rst),
            .set_mask_i (set_mask),
            .clr_mask_i (clr_mask),
            .wfi_i      (core_wfi_i[c*CORE_SLOTS +: CORE_SLOTS]),
            .wfe_i      (core_wfe_i[c*CORE_SLOTS +: CORE_SLOTS]),
            .dbgack_i   (core_dbgack_i[c*CORE_SLOTS +: CORE_SLOTS]),
            .lines_o    (line_rst_o[c*LINE_BITS +: LINE_BITS]),
            .status_o   (status_arr[c])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (sel.kind == REG_STATUS && sel.cluster == 2'(c)) begin
                bus_rdata_o = status_arr[c];
            end
        end
    end
endmodule

// File: rtl/mcrst_checker.sv
module mcrst_checker #(
    parameter int NUM_CLUSTERS = 4,
    parameter int RELEASE_LAG  = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic [15:0]               bus_addr_i,
    input logic                      bus_wr_i,
    input logic [31:0]               bus_wdata_i,
    input logic [31:0]               bus_rdata_o,
    input logic [4*NUM_CLUSTERS-1:0]  core_wfi_i,
    input logic [4*NUM_CLUSTERS-1:0]  core_wfe_i,
    input logic [4*NUM_CLUSTERS-1:0]  core_dbgack_i,
    input logic [14*NUM_CLUSTERS-1:0] line_rst_o
);
    logic [14*NUM_CLUSTERS-1:0] boot_lines;
    logic                       any_status;
    logic [1:0]                 since_rst;
    logic                       unused_lag;

    assign unused_lag = (RELEASE_LAG > 0);

    always_comb begin
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            boot_lines[c*14 +: 14] = (c == 0) ? 14'h1CEE : 14'h3FFF;
        end
    end

    always_comb begin
        any_status = 1'b0;
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (bus_addr_i == 16'h1520 + 16'(8 * c)) any_status = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7
    boot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (line_rst_o == boot_lines));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !any_status |-> (bus_rdata_o == 32'h0));

    // R9
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata_o[15:14] == 2'b00) && (bus_rdata_o[31:28] == 4'h0));

    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_chk
        logic [13:0] touched;
        logic        is_stat;

        assign touched = (bus_wr_i && (bus_addr_i == 16'h0520 + 16'(8 * c) ||
                                       bus_addr_i == 16'h0524 + 16'(8 * c)))
                         ? bus_wdata_i[13:0] : 14'h0;
        assign is_stat = (bus_addr_i == 16'h1520 + 16'(8 * c));

        // R5
        no_early_change_chk: assert property (@(posedge clk) disable iff (rst)
            (|touched) |=> ((line_rst_o[c*14 +: 14] & $past(touched)) ==
                            ($past(line_rst_o[c*14 +: 14]) & $past(touched))));

        // R4
        status_mirror_chk: assert property (@(posedge clk) disable iff (rst)
            is_stat |-> (bus_rdata_o[13:0] == line_rst_o[c*14 +: 14]));

        // R8
        idle_sync_chk: assert property (@(posedge clk) disable iff (rst)
            (is_stat && since_rst >= 2'd2) |->
                (bus_rdata_o[27:16] == {$past(core_dbgack_i[c*4 +: 4], 2),
                                        $past(core_wfe_i[c*4 +: 4], 2),
                                        $past(core_wfi_i[c*4 +: 4], 2)}));
    end
endmodule

bind mcrst_top mcrst_checker #(
    .NUM_CLUSTERS (NUM_CLUSTERS),
    .RELEASE_LAG  (RELEASE_LAG)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_addr_i    (bus_addr_i),
    .bus_wr_i      (bus_wr_i),
    .bus_wdata_i   (bus_wdata_i),
    .bus_rdata_o   (bus_rdata_o),
    .core_wfi_i    (core_wfi_i),
    .core_wfe_i    (core_wfe_i),
    .core_dbgack_i (core_dbgack_i),
    .line_rst_o    (line_rst_o)
);

// File: tb/mcrst_top_tb_top.sv
`timescale 1ns/1ps
module mcrst_top_tb_top;
    localparam int NC  = 4;
    localparam int LAG = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [4*NC-1:0]  core_wfi_i = '0;
    logic [4*NC-1:0]  core_wfe_i = '0;
    logic [4*NC-1:0]  core_dbgack_i = '0;
    logic [14*NC-1:0] line_rst_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        bit          is_line;
        int          cl;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    mcrst_top #(.NUM_CLUSTERS(NC), .RELEASE_LAG(LAG)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_addr_i    (bus_addr_i),
        .bus_wr_i      (bus_wr_i),
        .bus_wdata_i   (bus_wdata_i),
        .bus_rdata_o   (bus_rdata_o),
        .core_wfi_i    (core_wfi_i),
        .core_wfe_i    (core_wfe_i),
        .core_dbgack_i (core_dbgack_i),
        .line_rst_o    (line_rst_o)
    );

    // monitor: pops one expected item per cycle, sampled 1 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_line ? 32'(line_rst_o[it.cl*14 +: 14]) : bus_rdata_o;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // write is taken at the rising edge between the two falling edges
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i  = a;
        bus_wdata_i = d;
        bus_wr_i    = 1'b1;
        @(negedge clk);
        bus_wr_i    = 1'b0;
    endtask

    task automatic read_check(input logic [15:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr_i = a;
        it.is_line = 1'b0; it.cl = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic line_check(input int c, input logic [13:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_line = 1'b1; it.cl = c; it.exp = 32'(e); it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;

        // R7 / R4: boot state
        read_check(16'h1520, 32'h0000_1CEE, "R7 boot status cluster0");
        read_check(16'h1528, 32'h0000_3FFF, "R7 boot status cluster1");
        read_check(16'h1530, 32'h0000_3FFF, "R7 boot status cluster2");
        read_check(16'h1538, 32'h0000_3FFF, "R7 boot status cluster3");
        line_check(0, 14'h1CEE, "R7 R4 boot lines cluster0");
        line_check(3, 14'h3FFF, "R7 boot lines cluster3");
        // R9 / R1: control readback and out-of-map reads
        read_check(16'h0520, 32'h0, "R9 assert register reads zero");
        read_check(16'h1540, 32'h0, "R1 R9 status beyond last cluster reads zero");
        read_check(16'h1521, 32'h0, "R9 misaligned status read zero");

        // R5 / R2 / R3: release core1 lines of cluster0, high bits ignored
        bus_write(16'h0524, 32'h8000_C422);
        idle(LAG - 2);
        read_check(16'h1520, 32'h0000_1CEE, "R5 release not visible at lag-1");
        read_check(16'h1520, 32'h0000_18CC, "R5 R2 release visible at lag");
        line_check(0, 14'h18CC, "R4 lines follow release");

        // R3: zero write has no effect; assert only core1 logic (bit 1)
        bus_write(16'h0524, 32'h0);
        idle(LAG);
        read_check(16'h1520, 32'h0000_18CC, "R3 zero write no change");
        bus_write(16'h0520, 32'h0000_0002);
        idle(LAG - 2);
        read_check(16'h1520, 32'h0000_18CC, "R5 assert not visible at lag-1");
        read_check(16'h1520, 32'h0000_18CE, "R3 R2 assert core1 logic bit1");

        // R1: cluster3 release of cluster debug (bit 13)
        bus_write(16'h053C, 32'h0000_2000);
        idle(LAG - 1);
        read_check(16'h1538, 32'h0000_1FFF, "R1 cluster3 release via 0x53C");
        read_check(16'h1530, 32'h0000_3FFF, "R1 cluster2 untouched");
        line_check(3, 14'h1FFF, "R1 lines cluster3");

        // R6: two lines of cluster1 written five cycles apart
        bus_write(16'h052C, 32'h0000_0211);
        idle(3);
        bus_write(16'h052C, 32'h0000_0422);
        idle(10);
        read_check(16'h1528, 32'h0000_3DEE, "R6 first line at its own lag");
        idle(3);
        read_check(16'h1528, 32'h0000_3DEE, "R6 second line not yet");
        read_check(16'h1528, 32'h0000_39CC, "R6 second line at its own lag");

        // R6: rewrite restarts the delay (cluster2 L2, bit 8)
        bus_write(16'h0534, 32'h0000_0100);
        idle(3);
        bus_write(16'h0534, 32'h0000_0100);
        idle(10);
        read_check(16'h1530, 32'h0000_3FFF, "R6 restarted delay not done at first lag");
        idle(3);
        read_check(16'h1530, 32'h0000_3FFF, "R6 restarted delay lag-1");
        read_check(16'h1530, 32'h0000_3EFF, "R6 restarted delay complete");

        // R6: release cancelled by a later assert
        bus_write(16'h0534, 32'h0000_2000);
        bus_write(16'h0530, 32'h0000_2000);
        idle(LAG - 3);
        read_check(16'h1530, 32'h0000_3EFF, "R6 cancelled release never shows");
        idle(4);
        read_check(16'h1530, 32'h0000_3EFF, "R6 last write wins held");

        // R9: writes to unmapped addresses and to status are ignored
        bus_write(16'h0540, 32'h0000_FFFF);
        bus_write(16'h0544, 32'h0000_FFFF);
        bus_write(16'h1528, 32'h0000_FFFF);
        bus_write(16'h0521, 32'h0000_FFFF);
        bus_write(16'h052D, 32'h0000_FFFF);
        idle(LAG + 2);
        read_check(16'h1520, 32'h0000_18CE, "R9 cluster0 after ignored writes");
        read_check(16'h1528, 32'h0000_39CC, "R9 cluster1 after ignored writes");
        read_check(16'h1530, 32'h0000_3EFF, "R9 cluster2 after ignored writes");
        read_check(16'h1538, 32'h0000_1FFF, "R9 cluster3 after ignored writes");
        line_check(1, 14'h39CC, "R9 lines cluster1 unchanged");
        read_check(16'h0524, 32'h0, "R9 release register reads zero");

        // R8: idle inputs through two flops
        @(negedge clk);
        core_wfi_i    = 16'h0040;
        core_wfe_i    = 16'h0080;
        core_dbgack_i = 16'h1000;
        read_check(16'h1528, 32'h0000_39CC, "R8 idle not visible after one edge");
        read_check(16'h1528, 32'h0084_39CC, "R8 wfi bit18 wfe bit23 after two edges");
        read_check(16'h1538, 32'h0100_1FFF, "R8 dbgack cluster3 core0 bit24");
        line_check(1, 14'h39CC, "R8 idle inputs leave lines alone");
        @(negedge clk);
        core_wfi_i    = '0;
        core_wfe_i    = '0;
        core_dbgack_i = '0;
        idle(3);
        read_check(16'h1528, 32'h0000_39CC, "R8 idle cleared");

        idle(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule